// File: doc/BRIEF.md
# Trapping Set Neutralization Message Network

This block runs the neutralization phase of an iterative low-density parity-check decoder. When the decoder sees its syndrome freeze at a nonzero value, it hands this block the vector of unsatisfied check nodes and pulses `start`. Configuration loaded beforehand then steers short messages through a fixed Tanner graph. Unsatisfied check nodes start messages on selected links. Variable nodes that receive a message mark themselves for neutralization and may pass it on. Check nodes relay messages from one link to another according to per-link masks.

The graph is fixed at elaboration by the `CONN` parameter. Edges are numbered check by check: edge `e = j*DEG_C + q` is link `q` of check `j`, and field `CONN[e*VW +: VW]` names the variable at its far end. The network runs `nt_cycles` rounds and then pulses `done`. The resulting mask tells the decoder datapath which variable nodes must have their intrinsic and outgoing extrinsic values zeroed before ordinary iterations resume.

Top module: `ntz_net`

## Requirements
- R1: During and right after reset, `nmask` is all zero and `done` is low.
- R2: A `start` accepted while idle clears `nmask`. In the same clock it samples `chk_unsat` and queues a message on every edge `e` whose check is unsatisfied and whose initiation bit `chk_init[e]` is 1.
- R3: A variable node that receives a message sets its bit of `nmask`. The bit stays set until the next accepted `start`.
- R4: A variable node whose `var_fwd` bit is 1 sends a received message to all of its other edges, but not back on the edge it arrived on. With the bit at 0 it sends nothing.
- R5: A check node that receives a message on its link `p` sends it on its link `q` exactly when bit `p` of edge `e = j*DEG_C+q`'s forwarding word `chk_fwd[e*DEG_C +: DEG_C]` is 1.
- R6: Each round is one clock of check-to-variable delivery followed by one clock of variable-to-check delivery, one hop per clock. After `nt_cycles` rounds the run stops, messages still in flight are dropped, and `nmask` does not change while idle.
- R7: `done` is high for exactly one clock. It is high in the clock that follows the `2*nt_cycles`-th rising edge after the edge that accepted `start`. With `nt_cycles` = 0 it rises right after the accepting edge, and `nmask` is left all zero.
- R8: With all initiation and forwarding configuration at zero, no variable node is ever marked, whatever the check pattern.
- R9: A `start` pulse that arrives while a run is in progress is ignored: the mask result and the timing of `done` are those of the run already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| nt_cycles | input | CW | Number of rounds, sampled at start |
| chk_unsat | input | N_CHK | 1 marks an unsatisfied check node |
| chk_init | input | N_CHK*DEG_C | Initiation bit per edge |
| chk_fwd | input | N_CHK*DEG_C*DEG_C | Forwarding word per edge, indexed by incoming link |
| var_fwd | input | N_VAR | Forwarding bit per variable node |
| nmask | output | N_VAR | Variable nodes to be neutralized |
| done | output | 1 | One-clock pulse at the end of a run |

## Verification
The assertions assume that the configuration inputs stay constant while a run is in progress, since edges are evaluated against them in every half-round. They also assume that `start` is a plain pulse, though repeats while busy are allowed. The stimulus changes configuration only between runs and drives it on the falling edge. The sweep runs every check pattern on an eight-variable regular graph that embeds a four-variable trapping set with two odd-degree checks. It uses several round counts and three configuration sets, and includes a second `start` inside a run.

// File: rtl/ntz_pkg.sv
package ntz_pkg;
   typedef enum logic [1:0] {
      NZ_IDLE = 2'd0,
      NZ_VAR  = 2'd1,
      NZ_CHK  = 2'd2
   } nz_phase_e;
endpackage

// File: rtl/ntz_check_node.sv
module ntz_check_node #(
   parameter int DEG = 6
) (
   input  logic             unsat,
   input  logic [DEG-1:0]   init,
   input  logic [DEG*DEG-1:0] fwd,
   input  logic [DEG-1:0]   v2c,
   output logic [DEG-1:0]   init_out,
   output logic [DEG-1:0]   fwd_out
);
   assign init_out = {DEG{unsat}} & init;

   // outgoing link q listens to incoming links selected by its own word
   for (genvar q = 0; q < DEG; q++) begin : g_link
      assign fwd_out[q] = |(v2c & fwd[q*DEG +: DEG]);
   end
endmodule

// File: rtl/ntz_var_node.sv
module ntz_var_node #(
   parameter int N_EDGE = 18,
   parameter int VW     = 3,
   parameter logic [N_EDGE*VW-1:0] CONN = '0,
   parameter int MY_ID  = 0
) (
   input  logic [N_EDGE-1:0] c2v,
   input  logic              fwd_en,
   output logic              hit,
   output logic [N_EDGE-1:0] v2c_part
);
   logic [N_EDGE-1:0] mine;

   for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
      assign mine[e] = (CONN[e*VW +: VW] == VW'(MY_ID));
      // every own edge except the one a message came in on
      assign v2c_part[e] = fwd_en & mine[e]
                         & (|(c2v & mine & ~(N_EDGE'(1) << e)));
   end

   assign hit = |(c2v & mine);
endmodule

// File: rtl/ntz_seq.sv
module ntz_seq
   import ntz_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] nt_cycles,
   output logic          load,
   output logic          var_step,
   output logic          chk_step,
   output logic          busy,
   output logic          done
);
   nz_phase_e     phase;
   logic [CW-1:0] cnt, nt_q;

   assign busy     = (phase != NZ_IDLE);
   assign load     = start && (phase == NZ_IDLE);
   assign var_step = (phase == NZ_VAR);
   assign chk_step = (phase == NZ_CHK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= NZ_IDLE;
         cnt   <= '0;
         nt_q  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            NZ_IDLE: if (start) begin
               nt_q <= nt_cycles;
               cnt  <= CW'(1);
               if (nt_cycles == '0) done  <= 1'b1;
               else                 phase <= NZ_VAR;
            end
            NZ_VAR: phase <= NZ_CHK;
            NZ_CHK: if (cnt == nt_q) begin
               phase <= NZ_IDLE;
               done  <= 1'b1;
            end else begin
               cnt   <= cnt + CW'(1);
               phase <= NZ_VAR;
            end
            default: phase <= NZ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ntz_net.sv
module ntz_net #(
   parameter int N_VAR = 8,
   parameter int N_CHK = 8,
   parameter int DEG_C = 3,
   parameter int CW    = 4,
   parameter logic [N_CHK*DEG_C*$clog2(N_VAR)-1:0] CONN = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [CW-1:0]                nt_cycles,
   input  logic [N_CHK-1:0]             chk_unsat,
   input  logic [N_CHK*DEG_C-1:0]       chk_init,
   input  logic [N_CHK*DEG_C*DEG_C-1:0] chk_fwd,
   input  logic [N_VAR-1:0]             var_fwd,
   output logic [N_VAR-1:0]             nmask,
   output logic                         done
);
   localparam int VW = $clog2(N_VAR);
   localparam int NE = N_CHK * DEG_C;

   if (N_VAR < 2)  begin : g_bad_var $error("N_VAR must be at least 2"); end
   if (DEG_C < 2)  begin : g_bad_deg $error("DEG_C must be at least 2"); end
   if (CW < 1)     begin : g_bad_cw  $error("CW must be at least 1");   end

   logic          load, var_step, chk_step, busy;
   logic [NE-1:0] c2v_q, v2c_q, init_all, c2v_next, v2c_next;
   logic [N_VAR-1:0] hit;
   logic [NE-1:0] part [N_VAR];

   ntz_seq #(.CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .nt_cycles(nt_cycles),
      .load(load), .var_step(var_step), .chk_step(chk_step),
      .busy(busy), .done(done)
   );

   for (genvar j = 0; j < N_CHK; j++) begin : g_chk
      ntz_check_node #(.DEG(DEG_C)) u_cn (
         .unsat   (chk_unsat[j]),
         .init    (chk_init[j*DEG_C +: DEG_C]),
         .fwd     (chk_fwd[j*DEG_C*DEG_C +: DEG_C*DEG_C]),
         .v2c     (v2c_q[j*DEG_C +: DEG_C]),
         .init_out(init_all[j*DEG_C +: DEG_C]),
         .fwd_out (c2v_next[j*DEG_C +: DEG_C])
      );
   end

   for (genvar i = 0; i < N_VAR; i++) begin : g_var
      ntz_var_node #(.N_EDGE(NE), .VW(VW), .CONN(CONN), .MY_ID(i)) u_vn (
         .c2v(c2v_q), .fwd_en(var_fwd[i]), .hit(hit[i]), .v2c_part(part[i])
      );
   end

   always_comb begin
      v2c_next = '0;
      for (int i = 0; i < N_VAR; i++) v2c_next = v2c_next | part[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmask <= '0;
         c2v_q <= '0;
         v2c_q <= '0;
      end else if (load) begin
         nmask <= '0;
         c2v_q <= init_all;
         v2c_q <= '0;
      end else if (var_step) begin
         nmask <= nmask | hit;
         v2c_q <= v2c_next;
         c2v_q <= '0;
      end else if (chk_step) begin
         c2v_q <= c2v_next;
         v2c_q <= '0;
      end
   end
endmodule

// File: rtl/ntz_net_chk.sv
module ntz_net_chk #(
   parameter int N_VAR = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [N_VAR-1:0] nmask
);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy || start) && !busy));
   // R3
   mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (($past(nmask) & ~nmask) == '0));
   // R2
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (nmask == '0));
   // R6
   idle_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ((nmask & ~$past(nmask)) == '0));
endmodule

bind ntz_net ntz_net_chk #(.N_VAR(N_VAR)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .done(done), .nmask(nmask)
);

// File: tb/ntz_net_test.sv
module ntz_net_test;
   localparam int NV = 8, NC = 8, D = 3, CW = 4;
   localparam int NE = NC * D;
   localparam int LIST [NE] = '{1,4,5, 3,6,7, 1,0,4, 3,0,5,
                                0,2,6, 1,2,7, 3,2,7, 4,5,6};

   function automatic logic [NE*3-1:0] pack_conn();
      logic [NE*3-1:0] r;
      r = '0;
      for (int e = 0; e < NE; e++) r[e*3 +: 3] = 3'(LIST[e]);
      return r;
   endfunction
   localparam logic [NE*3-1:0] CONN_TB = pack_conn();

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [CW-1:0] nt_cycles = '0;
   logic [NC-1:0] chk_unsat = '0;
   logic [NE-1:0] chk_init = '0;
   logic [NE*D-1:0] chk_fwd = '0;
   logic [NV-1:0] var_fwd = '0;
   logic [NV-1:0] nmask;
   logic done;
   int errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   ntz_net #(.N_VAR(NV), .N_CHK(NC), .DEG_C(D), .CW(CW), .CONN(CONN_TB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .nt_cycles(nt_cycles),
      .chk_unsat(chk_unsat), .chk_init(chk_init), .chk_fwd(chk_fwd),
      .var_fwd(var_fwd), .nmask(nmask), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // mode 0: full steering, 1: no variable relay, 2: nothing configured
   function automatic logic [NV-1:0] model(int mode, logic [NC-1:0] u, int nt);
      logic [NV-1:0] m;
      m = '0;
      if (mode == 2 || nt == 0) return m;
      m[1] = u[0];
      m[3] = u[1];
      if (mode == 0 && nt >= 2) begin
         m[0] = u[0];
         m[2] = u[0];
      end
      return m;
   endfunction

   task automatic set_cfg(input int mode);
      chk_init = '0; chk_fwd = '0; var_fwd = '0;
      if (mode != 2) begin
         chk_init[0] = 1'b1;          // check 0 link 0 -> var 1
         chk_init[3] = 1'b1;          // check 1 link 0 -> var 3
         chk_fwd[7*D + 0]  = 1'b1;    // check 2: link 0 in, link 1 out (var 0)
         chk_fwd[16*D + 0] = 1'b1;    // check 5: link 0 in, link 1 out (var 2)
      end
      if (mode == 0) var_fwd[1] = 1'b1;
   endtask

   task automatic run(input int mode, input logic [NC-1:0] u, input int nt,
                      input bit poke);
      logic [NV-1:0] exp;
      exp = model(mode, u, nt);
      @(negedge clk);
      start = 1'b1; chk_unsat = u; nt_cycles = CW'(nt);
      @(negedge clk);
      start = 1'b0;
      if (nt > 0) begin
         if (poke) begin
            start = 1'b1; chk_unsat = '0; nt_cycles = '0;
            @(negedge clk);
            start = 1'b0;
            repeat (2*nt - 2) @(negedge clk);
         end else begin
            repeat (2*nt - 1) @(negedge clk);
         end
         chk(done == 1'b0, "R7 done early", 32'(done), 0);
         @(negedge clk);
      end
      chk(done == 1'b1, poke ? "R9 done time" : "R7 done", 32'(done), 1);
      chk(nmask == exp, poke ? "R9 mask" : (mode == 2 ? "R8 mask" :
          (mode == 1 ? "R4 mask" : "R5 R6 mask")), 32'(nmask), 32'(exp));
      @(negedge clk);
      chk(done == 1'b0, "R7 done width", 32'(done), 0);
      chk(nmask == exp, "R3 sticky", 32'(nmask), 32'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(nmask == '0 && done == 1'b0, "R1 in reset", 32'({done, nmask}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nmask == '0 && done == 1'b0, "R1 after reset", 32'({done, nmask}), 0);

      set_cfg(0);
      // r2_ initiation and r6_ round count, every check pattern
      for (int nt = 0; nt < 4; nt++)
         for (int u = 0; u < 256; u++) run(0, NC'(u), nt, 1'b0);
      run(0, 8'h03, 9, 1'b0);
      run(0, 8'hFF, 2, 1'b0);
      run(0, 8'h00, 2, 1'b0);            // R2 clears prior mask
      run(0, 8'h03, 3, 1'b1);            // R9 start while busy
      run(0, 8'h01, 2, 1'b1);
      set_cfg(1);
      for (int u = 0; u < 256; u++) run(1, NC'(u), 3, 1'b0);
      set_cfg(2);
      for (int u = 0; u < 256; u++) run(2, NC'(u), 3, 1'b0);
      repeat (4) @(negedge clk);
      chk(nmask == '0, "R6 idle hold", 32'(nmask), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule